// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

A purely combinational integer datapath unit that takes two operands and a 4-bit operation code and returns a result word together with carry, overflow and zero indications. It covers signed and unsigned addition and subtraction, four bitwise operations, and signed and unsigned less-than comparison. Any immediate extension is done before the operands reach this block; shifting, multiplication, division and upper-immediate loading are handled elsewhere.

One adder serves every arithmetic mode. Subtraction and both comparisons feed it the inverted second operand with a carry-in of one. The adder is organised as fixed-size lookahead blocks whose block carries skip forward through the block propagate term. The width and the block size are parameters, so the same source builds a narrow copy for exhaustive checking.

Top module: `alu_core`

## Requirements
- R1: Codes 0x0 (signed add) and 0x1 (unsigned add) give res_o = (a_i + b_i) mod 2^WIDTH, and carry_o equals bit WIDTH of the full sum.
- R2: Codes 0x2 (signed subtract) and 0x3 (unsigned subtract) give res_o = (a_i - b_i) mod 2^WIDTH, and carry_o is 1 exactly when a_i >= b_i as unsigned numbers, that is when no borrow occurs.
- R3: ovf_o is 1 for code 0x0 or 0x2 exactly when the two's-complement result falls outside the signed range of WIDTH bits; for codes 0x1 and 0x3 ovf_o is always 0.
- R4: Codes 0x4, 0x5, 0x6 and 0x7 give bitwise AND, OR, XOR and NOR of the operands respectively.
- R5: Code 0xA gives res_o = 1 when a_i < b_i as two's-complement numbers, else 0, with all bits above bit 0 cleared, including when a_i - b_i overflows.
- R6: Code 0xB gives res_o = 1 when a_i < b_i as unsigned numbers, else 0, with all bits above bit 0 cleared.
- R7: For codes 0x4 to 0x7, 0xA and 0xB, carry_o and ovf_o are both 0.
- R8: Codes 0x8, 0x9 and 0xC to 0xF give res_o = 0 with carry_o and ovf_o both 0.
- R9: zero_o is 1 exactly when every bit of res_o is 0, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| mode_i | input | 4 | Operation code |
| res_o | output | WIDTH | Result word |
| carry_o | output | 1 | Adder carry-out for add and subtract modes |
| ovf_o | output | 1 | Signed overflow for signed add and subtract |
| zero_o | output | 1 | Result is all zeros |

## Verification
The bench builds two copies side by side: one at WIDTH=32 with BLOCK=4, and one at WIDTH=4 with BLOCK=4. The narrow copy is swept over all 16 codes and all 256 operand pairs. This covers every overflow, borrow and sign case of the signed comparison, and every unused code. The wide copy is driven with corner operands: zero, one, the largest positive, the most negative, all ones and alternating patterns. These include the largest positive plus one, the most negative minus one and equal operands in every mode. Random operand pairs complete its coverage, and every expected value comes from integer arithmetic in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    OP_ADD  = 4'h0,
    OP_ADDU = 4'h1,
    OP_SUB  = 4'h2,
    OP_SUBU = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_XOR  = 4'h6,
    OP_NOR  = 4'h7,
    OP_SLT  = 4'hA,
    OP_SLTU = 4'hB
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_sel_e;
endpackage

// File: rtl/alu_cla_adder.sv
module alu_cla_adder #(
  parameter int WIDTH = 32,
  parameter int BLOCK = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_msb_o,
  output logic             cout_o
);
  localparam int NBLK = WIDTH / BLOCK;

  logic [NBLK:0]  blk_c;
  logic [WIDTH:0] c_all;

  assign blk_c[0] = cin_i;

  for (genvar blk = 0; blk < NBLK; blk++) begin : g_blk
    logic [BLOCK-1:0] g, p, c;
    logic             blk_g, blk_p;

    assign g = a_i[blk*BLOCK +: BLOCK] & b_i[blk*BLOCK +: BLOCK];
    assign p = a_i[blk*BLOCK +: BLOCK] ^ b_i[blk*BLOCK +: BLOCK];

    always_comb begin
      blk_g = 1'b0;
      blk_p = 1'b1;
      for (int k = 0; k < BLOCK; k++) begin
        blk_g = g[k] | (p[k] & blk_g);
        blk_p = blk_p & p[k];
      end
    end

    always_comb begin
      c[0] = blk_c[blk];
      for (int k = 1; k < BLOCK; k++) c[k] = g[k-1] | (p[k-1] & c[k-1]);
    end

    // block carry skips via group propagate
    assign blk_c[blk+1] = blk_g | (blk_p & blk_c[blk]);
    assign c_all[blk*BLOCK +: BLOCK] = c;
  end

  assign c_all[WIDTH] = blk_c[NBLK];
  assign sum_o   = a_i ^ b_i ^ c_all[WIDTH-1:0];
  assign c_msb_o = c_all[WIDTH-1];
  assign cout_o  = c_all[WIDTH];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit import alu_pkg::*; #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    case (logic_sel_e'(sel_i))
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/alu_compare.sv
module alu_compare (
  input  logic diff_sign_i,
  input  logic diff_ovf_i,
  input  logic diff_cout_i,
  input  logic unsigned_i,
  output logic lt_o
);
  // signed: sign corrected by overflow; unsigned: borrow = no carry-out
  assign lt_o = unsigned_i ? ~diff_cout_i : (diff_sign_i ^ diff_ovf_i);
endmodule

// File: rtl/alu_core.sv
module alu_core import alu_pkg::*; #(
  parameter int WIDTH = 32,
  parameter int BLOCK = 4
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [WIDTH-1:0]  res_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              zero_o
);
  alu_op_e          op;
  logic             do_sub;
  logic [WIDTH-1:0] b_eff, sum, lg_res;
  logic             c_msb, cout, ovf_raw, lt;

  assign op     = alu_op_e'(mode_i);
  assign do_sub = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
  assign b_eff  = do_sub ? ~b_i : b_i;

  alu_cla_adder #(.WIDTH(WIDTH), .BLOCK(BLOCK)) u_add (
    .a_i    (a_i),
    .b_i    (b_eff),
    .cin_i  (do_sub),
    .sum_o  (sum),
    .c_msb_o(c_msb),
    .cout_o (cout)
  );

  assign ovf_raw = c_msb ^ cout;

  alu_logic_unit #(.WIDTH(WIDTH)) u_log (
    .a_i  (a_i),
    .b_i  (b_i),
    .sel_i(mode_i[1:0]),
    .res_o(lg_res)
  );

  alu_compare u_cmp (
    .diff_sign_i(sum[WIDTH-1]),
    .diff_ovf_i (ovf_raw),
    .diff_cout_i(cout),
    .unsigned_i (mode_i[0]),
    .lt_o       (lt)
  );

  always_comb begin
    res_o   = '0;
    carry_o = 1'b0;
    ovf_o   = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        res_o   = sum;
        carry_o = cout;
        ovf_o   = ovf_raw;
      end
      OP_ADDU, OP_SUBU: begin
        res_o   = sum;
        carry_o = cout;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOR: res_o = lg_res;
      OP_SLT, OP_SLTU:               res_o = {{(WIDTH-1){1'b0}}, lt};
      default: ;
    endcase
  end

  assign zero_o = ~|res_o;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       mode_i,
  input logic [WIDTH-1:0] res_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             zero_o
);
  logic [WIDTH:0] add_ref, sub_ref;

  assign add_ref = {1'b0, a_i} + {1'b0, b_i};
  assign sub_ref = {1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, 1'b1};

  always_comb begin
    if (mode_i == 4'h0 || mode_i == 4'h1)
      a_r1_add_sum: assert ({carry_o, res_o} == add_ref);
    if (mode_i == 4'h2 || mode_i == 4'h3)
      a_r2_sub_diff: assert ({carry_o, res_o} == sub_ref);
    if (mode_i == 4'h1 || mode_i == 4'h3)
      a_r3_no_overflow: assert (!ovf_o);
    if (mode_i == 4'hA || mode_i == 4'hB)
      a_r5_cmp_upper_zero: assert (res_o[WIDTH-1:1] == '0);
    if (mode_i == 4'hB)
      a_r6_sltu_value: assert (res_o[0] == (a_i < b_i));
    if ((mode_i >= 4'h4 && mode_i <= 4'h7) || mode_i == 4'hA || mode_i == 4'hB)
      a_r7_flags_clear: assert (!carry_o && !ovf_o);
    if (mode_i == 4'h8 || mode_i == 4'h9 || mode_i >= 4'hC)
      a_r8_unused_quiet: assert (res_o == '0 && !carry_o && !ovf_o);
    if (zero_o)
      a_r9_zero_flag: assert (res_o == '0);
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .mode_i (mode_i),
  .res_o  (res_o),
  .carry_o(carry_o),
  .ovf_o  (ovf_o),
  .zero_o (zero_o)
);

// File: tb/alu_core_test.sv
module alu_core_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] a32, b32, r32;
  logic [3:0]  m32;
  logic        c32, o32, z32;
  logic [3:0]  a4, b4, r4, m4;
  logic        c4, o4, z4;

  alu_core #(.WIDTH(32), .BLOCK(4)) uut (
    .a_i(a32), .b_i(b32), .mode_i(m32),
    .res_o(r32), .carry_o(c32), .ovf_o(o32), .zero_o(z32)
  );

  alu_core #(.WIDTH(4), .BLOCK(4)) uut_nib (
    .a_i(a4), .b_i(b4), .mode_i(m4),
    .res_o(r4), .carry_o(c4), .ovf_o(o4), .zero_o(z4)
  );

  function automatic string req_tag(input logic [3:0] m);
    case (m)
      4'h0, 4'h1:             return "R1/R3/R9";
      4'h2, 4'h3:             return "R2/R3/R9";
      4'h4, 4'h5, 4'h6, 4'h7: return "R4/R7/R9";
      4'hA:                   return "R5/R7/R9";
      4'hB:                   return "R6/R7/R9";
      default:                return "R8/R9";
    endcase
  endfunction

  function automatic longint sext(input int w, input longint unsigned v);
    return v[w-1] ? longint'(v) - (longint'(1) << w) : longint'(v);
  endfunction

  task automatic model(input int w, input longint unsigned a, input longint unsigned b,
                       input logic [3:0] m, output longint unsigned r, output bit c, output bit o);
    longint unsigned mask = (64'd1 << w) - 1;
    longint sa = sext(w, a), sb = sext(w, b), s;
    longint lo = -(longint'(1) << (w - 1)), hi = (longint'(1) << (w - 1)) - 1;
    r = 0; c = 0; o = 0;
    case (m)
      4'h0, 4'h1: begin
        r = (a + b) & mask;
        c = ((a + b) >> w) != 0;
        s = sa + sb;
        o = (m == 4'h0) && (s < lo || s > hi);
      end
      4'h2, 4'h3: begin
        r = (a - b) & mask;
        c = a >= b;
        s = sa - sb;
        o = (m == 4'h2) && (s < lo || s > hi);
      end
      4'h4: r = a & b;
      4'h5: r = a | b;
      4'h6: r = a ^ b;
      4'h7: r = ~(a | b) & mask;
      4'hA: r = (sa < sb) ? 1 : 0;
      4'hB: r = (a < b) ? 1 : 0;
      default: ;
    endcase
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b, input logic [3:0] m);
    longint unsigned er; bit ec, eo, ez;
    @(posedge clk);
    a32 = a; b32 = b; m32 = m;
    @(negedge clk);
    model(32, longint'(a), longint'(b), m, er, ec, eo);
    ez = (er == 0);
    total++;
    if (r32 != er[31:0] || c32 != ec || o32 != eo || z32 != ez) begin
      bad++;
      $display("FAIL %s w=32 mode=%h a=%h b=%h res=%h/%h c=%b/%b o=%b/%b z=%b/%b",
               req_tag(m), m, a, b, r32, er[31:0], c32, ec, o32, eo, z32, ez);
    end
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b, input logic [3:0] m);
    longint unsigned er; bit ec, eo, ez;
    @(posedge clk);
    a4 = a; b4 = b; m4 = m;
    @(negedge clk);
    model(4, longint'(a), longint'(b), m, er, ec, eo);
    ez = (er == 0);
    total++;
    if (r4 != er[3:0] || c4 != ec || o4 != eo || z4 != ez) begin
      bad++;
      $display("FAIL %s w=4 mode=%h a=%h b=%h res=%h/%h c=%b/%b o=%b/%b z=%b/%b",
               req_tag(m), m, a, b, r4, er[3:0], c4, ec, o4, eo, z4, ez);
    end
  endtask

  initial begin
    logic [31:0] corner [8];
    a32 = '0; b32 = '0; m32 = '0;
    a4  = '0; b4  = '0; m4  = '0;
    corner = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
               32'hFFFF_FFFF, 32'hAAAA_5555, 32'h5555_AAAA, 32'h0000_FFFF};
    repeat (2) @(posedge clk);

    // idle inputs: add of zeros, R9 zero flag raised
    run32(32'h0, 32'h0, 4'h0);

    // R3 signed overflow edges, R1/R2 wraparound
    run32(32'h7FFF_FFFF, 32'h1, 4'h0);
    run32(32'h7FFF_FFFF, 32'h1, 4'h1);
    run32(32'h8000_0000, 32'h1, 4'h2);
    run32(32'h8000_0000, 32'h1, 4'h3);
    // R5 compare with overflowing difference
    run32(32'h8000_0000, 32'h1, 4'hA);
    run32(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'hA);

    // equal operands and corner pairs in every code (R1..R9)
    for (int m = 0; m < 16; m++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run32(corner[i], corner[j], 4'(m));

    // R4..R6 and R1/R2 on random words
    for (int n = 0; n < 800; n++) begin
      logic [31:0] ra = $urandom;
      logic [31:0] rb = $urandom;
      for (int m = 0; m < 16; m++) run32(ra, rb, 4'(m));
    end

    // exhaustive narrow sweep: R1..R9 incl. unused codes R8
    for (int m = 0; m < 16; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run4(4'(a), 4'(b), 4'(m));

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule